// File: doc/BRIEF.md
# Latched Fault Monitor with Deglitch

This block gathers the fault indications of a two-bridge motor gate driver and decides when each bridge must be switched off. Each bridge (A and B) supplies two raw inputs. One is an overcurrent comparator output, which must stay high through a deglitch window before it counts. The other is a gate predriver fault, which counts at once. Two chip-wide inputs, overtemperature and undervoltage, affect both bridges.

Per-bridge faults are sticky. Once set, a status bit and the bridge it belongs to stay in the fault state until software writes a 0 to that bit, or until reset. The chip-wide faults follow their condition and clear by themselves when it ends. One exception applies: the undervoltage bit holds its value while the sleep flag is asserted. An active-low fault output is pulled low while any status bit is set. It is released only when every bit has returned to zero, which is also the point at which both bridges are allowed to run again.

The deglitch window is `DG_BASE << code` clock cycles, where `code` is a 2-bit input. This gives four windows that double from one to the next. With the bench defaults they are 4, 8, 16 and 32 cycles. At the intended clock the four codes correspond to roughly 1, 2, 4 and 8 µs.

Top module: `fault_latch_monitor`

## Requirements
- R1: An overcurrent status bit sets after the raw overcurrent input has been sampled high on L consecutive rising clock edges, where L = DG_BASE << dg_code. The bit is visible after the L-th edge. A pulse of L-1 samples sets nothing.
- R2: A low sample on a raw overcurrent input restarts its deglitch count from zero. Two runs of L-1 high samples separated by one low sample set nothing.
- R3: A recognised overcurrent turns off only its own bridge (dis_a for A, dis_b for B) and pulls fault_n low.
- R4: A predriver fault input that is high for a single sample sets its status bit at the next edge. It turns off only its own bridge.
- R5: The four per-bridge bits hold until st_wr is asserted with a 0 in that bit position, or until reset. Writing a 1 leaves a bit unchanged. If a clear and a new set fall in the same cycle, the set wins.
- R6: The overtemperature and undervoltage bits each follow their raw input one cycle later. While either bit is set, both dis_a and dis_b are high.
- R7: While sleep is high, the undervoltage bit does not fall, even after uv_raw drops.
- R8: fault_n is low exactly when any status bit is set. It stays low while any sticky bit remains set, even after the chip-wide conditions have ended.
- R9: Status bit positions: bit0 overtemperature, bit1 A overcurrent, bit2 B overcurrent, bit3 A predriver, bit4 B predriver, bit5 undervoltage. st_wdata uses the same positions.
- R10: After reset, status is zero, both disables are low and fault_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_a_raw | input | 1 | Bridge A overcurrent comparator output |
| oc_b_raw | input | 1 | Bridge B overcurrent comparator output |
| pd_a_raw | input | 1 | Bridge A predriver fault |
| pd_b_raw | input | 1 | Bridge B predriver fault |
| ot_raw | input | 1 | Overtemperature condition |
| uv_raw | input | 1 | Undervoltage condition |
| dg_code | input | 2 | Deglitch window select |
| sleep | input | 1 | Sleep flag; freezes the undervoltage bit |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 6 | Status write data; 0 clears a sticky bit |
| status | output | 6 | Fault status bits |
| dis_a | output | 1 | Bridge A off |
| dis_b | output | 1 | Bridge B off |
| fault_n | output | 1 | Active-low fault output |

## Verification
The bench sweeps all four deglitch codes on both bridges with pulses of L-1 and L samples. A counter that is off by one cycle, or that reads the code with the wrong shift, therefore either misses a true fault or trips on a glitch. A split run separated by one low sample catches a counter that does not restart and so accumulates noise. The bench holds a fault high while clearing it to expose clear-over-set priority, which would drop a fault that is still present. It also checks that a write of ones changes nothing. Sleep with undervoltage, and a chip-wide fault that ends while a sticky bit remains, show whether the self-clearing bits and fault_n release too early.

// File: rtl/fault_latch_monitor.sv
module fault_latch_monitor #(
  parameter int DG_BASE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_a_raw,
  input  logic       oc_b_raw,
  input  logic       pd_a_raw,
  input  logic       pd_b_raw,
  input  logic       ot_raw,
  input  logic       uv_raw,
  input  logic [1:0] dg_code,
  input  logic       sleep,
  input  logic       st_wr,
  input  logic [5:0] st_wdata,
  output logic [5:0] status,
  output logic       dis_a,
  output logic       dis_b,
  output logic       fault_n
);
  localparam int DG_MAX = DG_BASE << 3;
  localparam int CW = $clog2(DG_MAX + 1);

  logic [CW-1:0] dg_len, dg_last;
  logic [CW-1:0] dg_cnt [2];
  logic [1:0] oc_raw, pd_raw, oc_hit, oc_q, pd_q, clr_oc, clr_pd;
  logic ot_q, uv_q;

  assign dg_len  = CW'(DG_BASE << dg_code);
  assign dg_last = dg_len - 1'b1;
  assign oc_raw  = {oc_b_raw, oc_a_raw};
  assign pd_raw  = {pd_b_raw, pd_a_raw};
  assign clr_oc  = st_wr ? ~st_wdata[2:1] : 2'b00;
  assign clr_pd  = st_wr ? ~st_wdata[4:3] : 2'b00;

  always_comb
    for (int i = 0; i < 2; i++)
      oc_hit[i] = oc_raw[i] && (dg_cnt[i] >= dg_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) dg_cnt[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++)
        if (!oc_raw[i])      dg_cnt[i] <= '0;
        else if (!oc_hit[i]) dg_cnt[i] <= dg_cnt[i] + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oc_q <= '0;
      pd_q <= '0;
      ot_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      oc_q <= oc_hit | (oc_q & ~clr_oc);
      pd_q <= pd_raw | (pd_q & ~clr_pd);
      ot_q <= ot_raw;
      uv_q <= uv_raw | (uv_q & sleep);
    end

  assign status  = {uv_q, pd_q[1], pd_q[0], oc_q[1], oc_q[0], ot_q};
  assign dis_a   = oc_q[0] | pd_q[0] | ot_q | uv_q;
  assign dis_b   = oc_q[1] | pd_q[1] | ot_q | uv_q;
  assign fault_n = ~|status;

  p_oc_needs_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] ##1 status[1] |-> $past(oc_a_raw));
  p_pd_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_b_raw |=> status[4] && dis_b);
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] && !(st_wr && !st_wdata[3]) |=> status[3]);
  p_global_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] || status[5]) |-> dis_a && dis_b);
  p_uv_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && sleep |=> status[5]);
  p_fault_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_a || dis_b) |-> !fault_n);
endmodule

// File: tb/fault_latch_monitor_test.sv
module fault_latch_monitor_test;
  logic clk = 0, rst_n = 0;
  logic [5:0] raw = '0;
  logic [1:0] dg_code = '0;
  logic sleep = 0, st_wr = 0;
  logic [5:0] st_wdata = '0;
  logic [5:0] status;
  logic dis_a, dis_b, fault_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_latch_monitor #(.DG_BASE(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .oc_a_raw(raw[1]), .oc_b_raw(raw[2]), .pd_a_raw(raw[3]), .pd_b_raw(raw[4]),
    .ot_raw(raw[0]), .uv_raw(raw[5]), .dg_code(dg_code), .sleep(sleep),
    .st_wr(st_wr), .st_wdata(st_wdata),
    .status(status), .dis_a(dis_a), .dis_b(dis_b), .fault_n(fault_n));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp_st);
    logic ea, eb, ef;
    ea = exp_st[1] | exp_st[3] | exp_st[0] | exp_st[5];
    eb = exp_st[2] | exp_st[4] | exp_st[0] | exp_st[5];
    ef = ~|exp_st;
    checks++;
    if (status !== exp_st || dis_a !== ea || dis_b !== eb || fault_n !== ef) begin
      errors++;
      $display("FAIL %s: status=%b dis_a=%b dis_b=%b fault_n=%b expected %b %b %b %b",
               req, status, dis_a, dis_b, fault_n, exp_st, ea, eb, ef);
    end
  endtask

  task automatic pulse(input int bitn, input int n);
    raw[bitn] = 1'b1; cyc(n); raw[bitn] = 1'b0;
  endtask

  task automatic wr(input logic [5:0] d);
    st_wr = 1'b1; st_wdata = d; cyc(1); st_wr = 1'b0; st_wdata = '0;
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    chk("R10 reset", 6'b0);

    for (int c = 0; c < 4; c++) begin
      for (int b = 1; b <= 2; b++) begin
        int len;
        len = 4 << c;
        dg_code = 2'(c);
        pulse(b, len - 1); cyc(1);
        chk("R1 short pulse", 6'b0);
        pulse(b, len - 1); cyc(1); pulse(b, len - 1); cyc(1);
        chk("R2 restart", 6'b0);
        pulse(b, len); cyc(1);
        chk("R1 R3 R9 full window", 6'(1 << b));
        wr(6'h3f);
        chk("R5 write ones", 6'(1 << b));
        wr(~6'(1 << b));
        chk("R5 R8 clear", 6'b0);
      end
    end

    dg_code = 2'd0;
    raw[1] = 1'b1; cyc(4);
    chk("R1 held input", 6'b000010);
    wr(6'b0);
    chk("R5 set beats clear", 6'b000010);
    raw[1] = 1'b0; wr(6'b0);
    chk("R5 clear after drop", 6'b0);

    pulse(3, 1); cyc(1);
    chk("R4 A predriver", 6'b001000);
    pulse(4, 1); cyc(1);
    chk("R4 B predriver", 6'b011000);
    wr(6'b110111);
    chk("R5 selective clear", 6'b010000);
    wr(6'b0);
    chk("R5 clear rest", 6'b0);

    raw[0] = 1'b1; cyc(1);
    chk("R6 overtemp set", 6'b000001);
    wr(6'b0); raw[0] = 1'b1;
    chk("R6 overtemp persists", 6'b000001);
    raw[0] = 1'b0; cyc(1);
    chk("R6 overtemp self-clear", 6'b0);
    raw[5] = 1'b1; cyc(1);
    chk("R6 undervoltage set", 6'b100000);
    raw[5] = 1'b0; cyc(1);
    chk("R6 undervoltage self-clear", 6'b0);

    raw[5] = 1'b1; cyc(1); sleep = 1'b1; raw[5] = 1'b0; cyc(3);
    chk("R7 held in sleep", 6'b100000);
    wr(6'b0);
    chk("R7 write in sleep", 6'b100000);
    sleep = 1'b0; cyc(1);
    chk("R7 released after sleep", 6'b0);

    pulse(3, 1); raw[0] = 1'b1; cyc(1);
    chk("R8 two faults", 6'b001001);
    raw[0] = 1'b0; cyc(1);
    chk("R8 sticky keeps fault low", 6'b001000);
    wr(6'b0);
    chk("R8 release", 6'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule